// File: doc/BRIEF.md
# Printer Port Register Emulator

This block presents a byte-wide register window that behaves like a standard printer port connected to nothing but a byte sink. A host reads and writes three registers: data, status and control. Each access is a single-cycle synchronous bus transaction. Writes to the control register are decoded as printer line changes. A rising edge on the strobe line hands the latched output byte to a downstream valid/ready port. Dropping the strobe with the line selected raises an interrupt if interrupts were already enabled. Forcing the init line low puts the status register into an idle value.

The block has no printer behind it, so each status read advances a scripted acknowledge/busy handshake. That lets polling drivers make progress. The interrupt output is a plain level that follows an internal pending flag. A status read clears that flag. The input data latch has no pin path. It is loaded only from a test port.

Top module: `prn_port_emu`

## Requirements
- R1: Address bits [2:0] select the register: 0 is data, 1 is status, 2 is control. A read at offsets 3 to 7 returns 0xFF. A write to offset 1 or to offsets 3 to 7 changes no state.
- R2: A control write stores the written value with bits 7 and 6 forced to 1. A control read returns the stored value.
- R3: A control write with init (bit 2) at 0 sets status to 0xD8.
- R4: A control write with init=1, select (bit 3)=1 and strobe (bit 0)=1 clears status bit 7. If the previously stored strobe bit was 0, the output data latch is emitted as one byte. A write with init=1 and select=0 leaves status unchanged.
- R5: A control write with init=1, select=1 and strobe=0 sets the interrupt-pending flag when the previously stored interrupt-enable (control bit 4) is 1.
- R6: A data write loads the output latch. A data read returns the input latch when direction (control bit 5) is 1, and the output latch otherwise.
- R7: A status read returns the status value held before the access and clears interrupt-pending.
- R8: After a status read, if status bit 7 and the stored strobe bit are both 0, the block updates ack (bit 6). If ack was 1, it is cleared. If ack was 0, ack and bit 7 are both set. In every other case status is unchanged.
- R9: The irq output is the level of the interrupt-pending flag, one cycle after the access that changes it.
- R10: Reset sets both data latches to 0xFF, status to 0xD9, control to 0xCC, pending to 0, and byte-valid to 0.
- R11: An emitted byte stays valid, with stable data, until byte_ready is seen high. Valid then drops in the next cycle. A new emission overwrites a held byte and keeps valid high, even in the cycle a previous byte is accepted.
- R12: A test-load pulse writes the input latch. Read side effects happen only when bus_sel=1 and bus_wr=0. With bus_sel=0, the status offset changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register offset (low 3 bits decoded) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the current state |
| tst_load | input | 1 | Load the input latch |
| tst_data | input | 8 | Value for the input latch |
| byte_valid | output | 1 | Emitted byte available |
| byte_ready | input | 1 | Sink accepts the byte |
| byte_data | output | 8 | Emitted byte |
| irq | output | 1 | Level interrupt |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a strobe-edge emission and sink acceptance of the previously held byte. The bench provokes this by holding a byte with byte_ready low, then issuing a new strobe edge while raising byte_ready. The byte port must show the new byte with valid still high. The second pair is a test-port load and a data read with direction set. Both are issued in one cycle, and the read must return the latch value from before the load. Random traffic repeats both collisions through a free-running random byte_ready and random test loads. Every cycle is compared against a bench model of the registers.

// File: rtl/prn_port_pkg.sv
package prn_port_pkg;
  localparam int PW = 8;

  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_STAT = 3'd1;
  localparam logic [2:0] OFS_CTRL = 3'd2;

  // control line positions
  localparam int C_STROBE = 0;
  localparam int C_INIT   = 2;
  localparam int C_SELECT = 3;
  localparam int C_INTEN  = 4;
  localparam int C_DIR    = 5;

  // status line positions
  localparam int S_ACK    = 6;
  localparam int S_NBUSY  = 7;

  localparam logic [PW-1:0] CTRL_FORCED = 8'hC0;
  localparam logic [PW-1:0] STAT_IDLE   = 8'hD8;
  localparam logic [PW-1:0] STAT_RESET  = 8'hD9;
  localparam logic [PW-1:0] CTRL_RESET  = 8'hCC;
  localparam logic [PW-1:0] LATCH_RESET = 8'hFF;
  localparam logic [PW-1:0] OPEN_READ   = 8'hFF;

  typedef struct packed {
    logic [PW-1:0] status;
    logic          emit;
    logic          set_pend;
  } ctrl_effect_t;

  function automatic logic [PW-1:0] ctrl_fix(input logic [PW-1:0] v);
    return v | CTRL_FORCED;
  endfunction

  // handshake step taken after each status read
  function automatic logic [PW-1:0] poll_step(input logic [PW-1:0] st,
                                              input logic          strobe_q);
    logic [PW-1:0] r;
    r = st;
    if (!st[S_NBUSY] && !strobe_q) begin
      if (st[S_ACK]) r[S_ACK] = 1'b0;
      else begin
        r[S_ACK]   = 1'b1;
        r[S_NBUSY] = 1'b1;
      end
    end
    return r;
  endfunction

  function automatic ctrl_effect_t ctrl_effect(input logic [PW-1:0] v,
                                               input logic [PW-1:0] st,
                                               input logic          strobe_q,
                                               input logic          inten_q);
    ctrl_effect_t e;
    e.status   = st;
    e.emit     = 1'b0;
    e.set_pend = 1'b0;
    if (!v[C_INIT]) begin
      e.status = STAT_IDLE;
    end else if (v[C_SELECT]) begin
      if (v[C_STROBE]) begin
        e.status[S_NBUSY] = 1'b0;
        e.emit = !strobe_q;
      end else begin
        e.set_pend = inten_q;
      end
    end
    return e;
  endfunction
endpackage

// File: rtl/prn_ctrl_decode.sv
module prn_ctrl_decode
  import prn_port_pkg::*;
(
  input  logic          ctrl_wr,
  input  logic [PW-1:0] wdata,
  input  logic [PW-1:0] status_q,
  input  logic          strobe_q,
  input  logic          inten_q,
  output logic [PW-1:0] ctrl_nxt,
  output logic [PW-1:0] status_nxt,
  output logic          emit,
  output logic          set_pend
);
  ctrl_effect_t eff;

  always_comb begin
    ctrl_nxt   = ctrl_fix(wdata);
    eff        = ctrl_effect(ctrl_nxt, status_q, strobe_q, inten_q);
    status_nxt = eff.status;
    emit       = ctrl_wr & eff.emit;
    set_pend   = ctrl_wr & eff.set_pend;
  end
endmodule

// File: rtl/prn_status_poll.sv
module prn_status_poll
  import prn_port_pkg::*;
(
  input  logic          stat_rd,
  input  logic [PW-1:0] status_q,
  input  logic          strobe_q,
  output logic [PW-1:0] status_nxt,
  output logic          clr_pend
);
  always_comb begin
    status_nxt = poll_step(status_q, strobe_q);
    clr_pend   = stat_rd;
  end
endmodule

// File: rtl/prn_byte_slot.sv
module prn_byte_slot #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             emit,
  input  logic [WIDTH-1:0] din,
  input  logic             ready,
  output logic             valid,
  output logic [WIDTH-1:0] data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (emit) begin
      valid <= 1'b1;
      data  <= din;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end

  // R11: a byte not taken stays put
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready && !emit) |=> (valid && $stable(data)));

  // R11 / R4: an emission lands on the port next cycle
  p_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    emit |=> (valid && data == $past(din)));

  // R11: accepted byte with no new emission retires
  p_retire_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ready && !emit) |=> !valid);
endmodule

// File: rtl/prn_port_emu.sv
module prn_port_emu
  import prn_port_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PW-1:0]     bus_wdata,
  output logic [PW-1:0]     bus_rdata,
  input  logic              tst_load,
  input  logic [PW-1:0]     tst_data,
  output logic              byte_valid,
  input  logic              byte_ready,
  output logic [PW-1:0]     byte_data,
  output logic              irq
);
  logic [2:0] reg_ofs;
  logic       rd_stb, wr_stb;
  logic       data_wr, ctrl_wr, stat_rd;

  logic [PW-1:0] dout_q, din_q, status_q, ctrl_q;
  logic          pend_q;

  logic [PW-1:0] dec_ctrl, dec_status, poll_status;
  logic          emit, set_pend, clr_pend;

  assign reg_ofs = bus_addr[2:0];
  assign rd_stb  = bus_sel & ~bus_wr;
  assign wr_stb  = bus_sel & bus_wr;
  assign data_wr = wr_stb && (reg_ofs == OFS_DATA);
  assign ctrl_wr = wr_stb && (reg_ofs == OFS_CTRL);
  assign stat_rd = rd_stb && (reg_ofs == OFS_STAT);

  prn_ctrl_decode u_dec (
    .ctrl_wr    (ctrl_wr),
    .wdata      (bus_wdata),
    .status_q   (status_q),
    .strobe_q   (ctrl_q[C_STROBE]),
    .inten_q    (ctrl_q[C_INTEN]),
    .ctrl_nxt   (dec_ctrl),
    .status_nxt (dec_status),
    .emit       (emit),
    .set_pend   (set_pend)
  );

  prn_status_poll u_poll (
    .stat_rd    (stat_rd),
    .status_q   (status_q),
    .strobe_q   (ctrl_q[C_STROBE]),
    .status_nxt (poll_status),
    .clr_pend   (clr_pend)
  );

  prn_byte_slot #(.WIDTH(PW)) u_slot (
    .clk   (clk),
    .rst_n (rst_n),
    .emit  (emit),
    .din   (dout_q),
    .ready (byte_ready),
    .valid (byte_valid),
    .data  (byte_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout_q   <= LATCH_RESET;
      din_q    <= LATCH_RESET;
      status_q <= STAT_RESET;
      ctrl_q   <= CTRL_RESET;
      pend_q   <= 1'b0;
    end else begin
      if (data_wr)  dout_q <= bus_wdata;
      if (tst_load) din_q  <= tst_data;
      if (ctrl_wr) begin
        ctrl_q   <= dec_ctrl;
        status_q <= dec_status;
      end else if (stat_rd) begin
        status_q <= poll_status;
      end
      if (clr_pend)      pend_q <= 1'b0;
      else if (set_pend) pend_q <= 1'b1;
    end
  end

  always_comb begin
    unique case (reg_ofs)
      OFS_DATA: bus_rdata = ctrl_q[C_DIR] ? din_q : dout_q;
      OFS_STAT: bus_rdata = status_q;
      OFS_CTRL: bus_rdata = ctrl_q;
      default:  bus_rdata = OPEN_READ;
    endcase
  end

  assign irq = pend_q;

  // R2: stored control keeps the written value with top bits set
  p_ctrl_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (ctrl_q == ($past(bus_wdata) | 8'hC0)));

  // R3: init low parks status
  p_init_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !bus_wdata[C_INIT]) |=> (status_q == 8'hD8));

  // R4: emission only on a strobe rising edge
  p_emit_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    emit |-> (ctrl_wr && !ctrl_q[C_STROBE] && bus_wdata[C_STROBE]
              && bus_wdata[C_INIT] && bus_wdata[C_SELECT]));

  // R5: irq rises only after a control write with interrupts enabled
  p_irq_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(ctrl_wr) && $past(ctrl_q[C_INTEN])));

  // R7: a status read drops the interrupt
  p_pend_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> !irq);

  // R8: ack falls on a poll while the line is busy and strobe low
  p_ack_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !status_q[S_NBUSY] && !ctrl_q[C_STROBE] && status_q[S_ACK])
      |=> !status_q[S_ACK]);

  // R12: no access leaves status untouched
  p_idle_stat_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |=> $stable(status_q));
endmodule

// File: tb/prn_port_emu_bench.sv
module prn_port_emu_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       tst_load = 1'b0;
  logic [7:0] tst_data = '0;
  logic       byte_valid, byte_ready = 1'b0;
  logic [7:0] byte_data;
  logic       irq;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // bench model of the register state
  logic [7:0] m_dout, m_din, m_st, m_ctl, m_byte;
  bit         m_pend, m_val;

  always #5 clk = ~clk;

  prn_port_emu u_prn_port_emu (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tst_load(tst_load), .tst_data(tst_data), .byte_valid(byte_valid),
    .byte_ready(byte_ready), .byte_data(byte_data), .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0:    return m_ctl[5] ? m_din : m_dout;
      3'd1:    return m_st;
      3'd2:    return m_ctl;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic string read_tag(input logic [2:0] a);
    case (a)
      3'd0:    return "R6 data read";
      3'd1:    return "R7 status read";
      3'd2:    return "R2 control read";
      default: return "R1 open offset";
    endcase
  endfunction

  task automatic model_reset();
    m_dout = 8'hFF; m_din = 8'hFF; m_st = 8'hD9; m_ctl = 8'hCC;
    m_pend = 0; m_val = 0; m_byte = 8'h00;
  endtask

  task automatic step(input bit sel, input bit wr, input logic [2:0] a,
                      input logic [7:0] wd, input bit tld, input logic [7:0] td,
                      input bit rdy);
    bit em;
    logic [7:0] v;
    @(negedge clk);
    bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    tst_load = tld; tst_data = td; byte_ready = rdy;
    #2;
    if (sel && !wr) chk(read_tag(a), bus_rdata, exp_read(a));
    @(posedge clk);
    em = 0;
    if (sel && wr) begin
      if (a == 3'd0) m_dout = wd;
      else if (a == 3'd2) begin
        v = wd | 8'hC0;
        if (v[2] == 1'b0) m_st = 8'hD8;
        else if (v[3]) begin
          if (v[0]) begin
            m_st[7] = 1'b0;
            if (m_ctl[0] == 1'b0) em = 1;
          end else if (m_ctl[4]) m_pend = 1;
        end
        m_ctl = v;
      end
    end
    if (sel && !wr && a == 3'd1) begin
      m_pend = 0;
      if (!m_st[7] && !m_ctl[0]) begin
        if (m_st[6]) m_st[6] = 1'b0;
        else m_st[7:6] = 2'b11;
      end
    end
    if (em) begin m_val = 1; m_byte = m_dout; end
    else if (rdy && m_val) m_val = 0;
    if (tld) m_din = td;
    #1;
    bus_sel = 0; tst_load = 0;
    chk("R9 irq level", {7'd0, irq}, {7'd0, m_pend});
    chk("R11 byte valid", {7'd0, byte_valid}, {7'd0, m_val});
    if (m_val) chk("R11 byte data", byte_data, m_byte);
  endtask

  task automatic rd(input logic [2:0] a, input bit rdy);
    step(1, 0, a, 8'h00, 0, 8'h00, rdy);
  endtask
  task automatic wr(input logic [2:0] a, input logic [7:0] d, input bit rdy);
    step(1, 1, a, d, 0, 8'h00, rdy);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0BAD_5EED));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset values
    @(negedge clk); #2;
    chk("R10 irq after reset", {7'd0, irq}, 8'd0);
    chk("R10 valid after reset", {7'd0, byte_valid}, 8'd0);
    rd(3'd0, 0); rd(3'd2, 0); rd(3'd1, 0);
    chk("R10 status 0xD9", exp_read(3'd1), 8'hD9);

    // R1 ignored writes, open reads
    wr(3'd1, 8'h00, 0); wr(3'd5, 8'h00, 0);
    rd(3'd3, 0); rd(3'd7, 0); rd(3'd1, 0); rd(3'd2, 0);

    // R4 strobe edge emits data latch; R8 polling script
    wr(3'd0, 8'hA5, 0);
    wr(3'd2, 8'h0D, 0);
    chk("R4 emitted byte", byte_data, 8'hA5);
    wr(3'd2, 8'h0C, 0);
    rd(3'd1, 0); chk("R8 ack cleared", exp_read(3'd1), 8'h19);
    rd(3'd1, 0); chk("R8 ack and busy set", exp_read(3'd1), 8'hD9);
    rd(3'd1, 1);

    // R11 overwrite of held byte, then emit while the sink accepts
    wr(3'd0, 8'h3C, 0); wr(3'd2, 8'h0D, 0); wr(3'd2, 8'h0C, 0);
    wr(3'd0, 8'h77, 0); wr(3'd2, 8'h0D, 1);
    chk("R11 new byte wins", byte_data, 8'h77);
    wr(3'd2, 8'h0C, 1); rd(3'd2, 0);

    // R5 interrupt, R7 cleared by status read, R12 idle poll
    wr(3'd2, 8'h1C, 0); wr(3'd2, 8'h1D, 0); wr(3'd2, 8'h1C, 0);
    step(0, 0, 3'd1, 8'h00, 0, 8'h00, 1);
    rd(3'd1, 0);

    // R3 init low
    wr(3'd2, 8'h00, 0); rd(3'd1, 0);
    chk("R3 status idle", exp_read(3'd1), 8'hD8);

    // R12 test load colliding with a direction read, R6
    wr(3'd2, 8'h2C, 0);
    step(1, 0, 3'd0, 8'h00, 1, 8'h5A, 0);
    rd(3'd0, 0);
    chk("R12 loaded latch", exp_read(3'd0), 8'h5A);

    // random traffic
    for (int i = 0; i < 6000; i++) begin
      int k;
      logic [7:0] d;
      k = $urandom_range(0, 99);
      d = 8'($urandom);
      if (k < 35) begin
        if ($urandom_range(0, 3) != 0) d[3:2] = 2'b11;
        step(1, 1, 3'd2, d, $urandom_range(0, 7) == 0, 8'($urandom), 1'($urandom));
      end else if (k < 65)
        step(1, 0, 3'd1, 8'h00, $urandom_range(0, 7) == 0, 8'($urandom), 1'($urandom));
      else if (k < 80)
        step(1, 1, 3'd0, d, $urandom_range(0, 7) == 0, 8'($urandom), 1'($urandom));
      else
        step(1'($urandom), 1'($urandom), 3'($urandom), d,
             $urandom_range(0, 3) == 0, 8'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule